// File: doc/BRIEF.md
# External Interrupt Capture Unit

This block turns active-low external interrupt pins into request flags for an interrupt controller. Each channel has its own synchronizer and trigger logic. A per-channel mode bit selects the trigger. With falling-edge sensing the flag is latched and cleared by hardware. With low-level sensing the flag simply tracks the pin.

The flag stays up until the controller vectors to that channel and pulses the acknowledge input. Software sees each channel as a two-bit field of a small control register, which it can read and write through a plain write strobe and a read-data bus. The register has no handshake at all.

Top module: `ext_irq_capture`

## Requirements
- R1: After reset every mode bit and flag bit reads 0 and every `irq_req` bit is 0.
- R2: The register holds channel c's mode at bit 2c and its flag at bit 2c+1. With the default two channels: bit 0 is the channel 0 mode, bit 1 the channel 0 flag, bit 2 the channel 1 mode and bit 3 the channel 1 flag.
- R3: With mode 1 (falling edge), a 1-to-0 change on a channel's pin sets its flag exactly SYNC_STAGES+1 clock cycles after the pin changes, and not earlier. A 0-to-1 change never sets it.
- R4: With mode 0 (low level), the flag equals the inverted pin, delayed by SYNC_STAGES+1 cycles, and is not latched.
- R5: With mode 1, an acknowledge pulse on a channel clears its flag on the next clock edge.
- R6: With mode 1, a detected falling edge in the same cycle as an acknowledge or a software write of 0 leaves the flag set.
- R7: A write loads the mode bits on the next edge. For channels whose mode was 1 before the write, it also loads the written flag bit.
- R8: With mode 0, an acknowledge or a flag write has no lasting effect: the flag keeps following the pin.
- R9: `irq_req[c]` always equals channel c's flag bit.
- R10: With mode 1, a pin held low after an acknowledge does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NUM_CH | Asynchronous active-low interrupt pins |
| ack | input | NUM_CH | Per-channel acknowledge, one-cycle pulse when vectored |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 2*NUM_CH | Register write data |
| reg_rdata | output | 2*NUM_CH | Register read data |
| irq_req | output | NUM_CH | Per-channel interrupt request |

## Verification
A pin change passes through SYNC_STAGES synchronizer flops and then the flag flop, so it shows up SYNC_STAGES+1 edges later. An acknowledge or a register write takes effect one edge later. The bench drives all inputs just after a falling clock edge. It counts rising edges from that point and samples on a later falling edge. It checks the cycle before a flag is due as well as the cycle it is due. For the edge/acknowledge collision, the acknowledge is placed on the one cycle in which the synchronized edge is visible.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  localparam int unsigned FIELD_W = 2;

  function automatic int unsigned mode_pos(input int unsigned ch);
    return ch * FIELD_W;
  endfunction

  function automatic int unsigned flag_pos(input int unsigned ch);
    return ch * FIELD_W + 1;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= 1'b1;
    else        stg_q[0] <= pin_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= 1'b1;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  endgenerate

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_fall_detect.sv
module irq_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  // A falling edge is a single-cycle event
  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/irq_chan_flag.sv
module irq_chan_flag
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic       fall_i,
  input  logic       ack_i,
  input  logic       wr_en_i,
  input  logic       wr_mode_i,
  input  logic       wr_flag_i,
  output trig_mode_e mode_o,
  output logic       flag_o
);
  trig_mode_e mode_q;
  logic       flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TRIG_LEVEL;
    end else if (wr_en_i) begin
      mode_q <= trig_mode_e'(wr_mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (mode_q == TRIG_LEVEL) begin
      flag_q <= ~lvl_i;
    end else if (fall_i) begin
      flag_q <= 1'b1;
    end else if (wr_en_i) begin
      flag_q <= wr_flag_i;
    end else if (ack_i) begin
      flag_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign flag_o = flag_q;

  p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_FALL && fall_i) |=> flag_q);

  p_level_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_LEVEL) |=> (flag_q == !$past(lvl_i)));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TRIG_FALL && ack_i && !fall_i && !wr_en_i) |=> !flag_q);

  p_mode_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mode_q == trig_mode_e'($past(wr_mode_i))));
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          pin_n,
  input  logic [NUM_CH-1:0]          ack,
  input  logic                       reg_wr_en,
  input  logic [FIELD_W*NUM_CH-1:0]  reg_wdata,
  output logic [FIELD_W*NUM_CH-1:0]  reg_rdata,
  output logic [NUM_CH-1:0]          irq_req
);
  localparam int unsigned REG_W = FIELD_W * NUM_CH;

  logic [NUM_CH-1:0] lvl, fall, flag;
  trig_mode_e        mode [NUM_CH];

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_n[c]),
        .lvl_o (lvl[c])
      );

      irq_fall_detect u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl[c]),
        .fall_o (fall[c])
      );

      irq_chan_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl[c]),
        .fall_i    (fall[c]),
        .ack_i     (ack[c]),
        .wr_en_i   (reg_wr_en),
        .wr_mode_i (reg_wdata[mode_pos(c)]),
        .wr_flag_i (reg_wdata[flag_pos(c)]),
        .mode_o    (mode[c]),
        .flag_o    (flag[c])
      );

      assign reg_rdata[mode_pos(c)] = mode[c];
      assign reg_rdata[flag_pos(c)] = flag[c];
      assign irq_req[c]             = flag[c];
    end
  endgenerate

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (reg_rdata == '0) || !rst_n);

  p_req_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_req) == $countones(reg_rdata & {NUM_CH{2'b10}}));

  initial begin
    if (REG_W != 2 * NUM_CH) $error("register width mismatch");
  end
endmodule

// File: tb/ext_irq_capture_tb.sv
module ext_irq_capture_tb_top;
  localparam int NCH = 2;
  localparam int SYN = 2;
  localparam int LAT = SYN + 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_n = '1;
  logic [NCH-1:0] ack = '0;
  logic           reg_wr_en = 1'b0;
  logic [2*NCH-1:0] reg_wdata = '0;
  logic [2*NCH-1:0] reg_rdata;
  logic [NCH-1:0] irq_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_capture #(.NUM_CH(NCH), .SYNC_STAGES(SYN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .ack(ack),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // R9 check rides along with every flag check
  task automatic chk_flag(input string req, input int c, input bit exp);
    chk(req, reg_rdata[2*c+1], exp);
    chk("R9", irq_req[c], exp);
  endtask

  task automatic wr(input logic [3:0] d);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    step(1);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    chk("R1", reg_rdata, 0);
    chk("R1", irq_req, 0);

    // R2/R7/R8 sweep over every write value
    for (int w = 0; w < 16; w++) begin
      logic [3:0] v, e2;
      v = w[3:0];
      wr(4'b0101);
      wr(v);
      chk("R7", reg_rdata, v);
      chk("R2", irq_req, {v[3], v[1]});
      step(1);
      e2 = {v[3] & v[2], v[2], v[1] & v[0], v[0]};
      chk("R8", reg_rdata, e2);
    end

    for (int c = 0; c < NCH; c++) begin
      // edge mode
      wr(4'b0101);
      pin_n[c] = 1'b0;
      step(LAT - 1);
      chk_flag("R3", c, 1'b0);
      step(1);
      chk_flag("R3", c, 1'b1);
      chk_flag("R3", 1 - c, 1'b0);
      ack[c] = 1'b1; step(1); ack[c] = 1'b0;
      chk_flag("R5", c, 1'b0);
      step(4);
      chk_flag("R10", c, 1'b0);
      pin_n[c] = 1'b1;
      step(LAT + 1);
      chk_flag("R3", c, 1'b0);

      // edge collides with ack
      wr(4'b0101 | (4'b0010 << (2 * c)));
      chk_flag("R7", c, 1'b1);
      pin_n[c] = 1'b0;
      step(LAT - 1);
      ack[c] = 1'b1; step(1); ack[c] = 1'b0;
      chk_flag("R6", c, 1'b1);
      ack[c] = 1'b1; step(1); ack[c] = 1'b0;
      chk_flag("R5", c, 1'b0);
      pin_n[c] = 1'b1;
      step(LAT + 1);

      // edge collides with write of 0
      pin_n[c] = 1'b0;
      step(LAT - 1);
      wr(4'b0101);
      chk_flag("R6", c, 1'b1);
      pin_n[c] = 1'b1;
      step(LAT + 1);
      wr(4'b0101);

      // level mode
      wr(4'b0000);
      pin_n[c] = 1'b0;
      step(LAT - 1);
      chk_flag("R4", c, 1'b0);
      step(1);
      chk_flag("R4", c, 1'b1);
      ack[c] = 1'b1; step(1); ack[c] = 1'b0;
      chk_flag("R8", c, 1'b1);
      wr(4'b0000);
      chk_flag("R8", c, 1'b1);
      pin_n[c] = 1'b1;
      step(LAT - 1);
      chk_flag("R4", c, 1'b1);
      step(1);
      chk_flag("R4", c, 1'b0);
      chk_flag("R4", 1 - c, 1'b0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule